// File: doc/BRIEF.md
# Configurable GPIO Port with Change Alert

This block is the register core of an eight-pin general-purpose port. A host writes and reads seven byte-wide registers through a simple indexed port. The registers set each pin's direction, its drive style (push-pull or open-drain) and its output level. They also hold a per-pin alert mask, a global alert enable, a fan-mode switch and a three-bit fan speed. For every pin the block produces an output enable and an output value, so a pad ring can build either drive style from them.

Pins that act as inputs are compared with their previous sample on every clock. Any level change, rising or falling, latches a flag in a status register. This happens whatever the alert settings are. Reading the status register returns the flags and clears them all. An active-low alert line falls when the global enable is set and a masked-in input changes. A status read or an acknowledge pulse from the serial front end, issued once the alert-response query has been answered, releases the line. The acknowledge leaves the status flags in place.

In fan mode the upper four pins are handed to an external fan sequencer. They become open-drain outputs that follow its drive pattern. They ignore the direction, drive-style and data settings and raise no flags.

Top module: `gpio_alert_port`

## Requirements
- R1: After reset every register reads 0 except data. Data resets to all ones, so a pin later made an open-drain output is released (pinOe=0). All pins start as inputs, pinOe is 0, alertN is 1 and fanOn is 0.
- R2: The register indices are 0 config, 1 direction, 2 drive type, 3 status, 4 mask, 5 data and 6 fan speed. Config keeps bit 0 (alert enable) and bit 1 (fan mode) and reads its other bits as 0. Fan speed keeps bits 2:0. Direction, drive type and mask keep all 8 bits. A write to index 3 has no effect.
- R3: A pin whose direction bit is 1 is an output. With drive-type bit 1 it is push-pull: pinOe=1 and pinOut equals the data bit. With drive-type bit 0 it is open-drain: a data bit of 0 gives pinOe=1 and pinOut=0, and a data bit of 1 gives pinOe=0.
- R4: An input pin has pinOe=0. Reading data returns the live pin level for inputs and the stored bit for outputs. Data bits written over inputs change neither the pins nor the readback.
- R5: A rising or falling edge on an input pin sets its status bit, whatever the enable and mask settings. Pins configured as outputs never set status bits.
- R6: A read of index 3 returns the flags and clears all of them on that clock. A change detected on the same clock as the clear survives it.
- R7: alertN falls one clock after a pin change when the enable is 1, the pin is an input and its mask bit is 1. Changes on unmasked pins, or changes made while the enable is 0, never pull it low, not even after the enable is set later.
- R8: An alertAck pulse or a status read releases alertN. After an acknowledge the status bits still read back.
- R9: With fan mode on, pins 7:4 are open-drain outputs: pin 4+j has pinOe equal to the inverse of fanDrive[j] and pinOut=0, whatever the direction, drive-type and data bits. These pins raise no status bits and no alert. fanOn and fanSpeed present config bit 1 and the fan speed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of index 3 clears status) |
| regIdx | input | 3 | Register index |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regIdx, combinational |
| pinIn | input | 8 | Synchronized pin levels |
| alertAck | input | 1 | One-cycle pulse: alert-response query answered |
| fanDrive | input | 4 | Fan sequencer pattern for pins 7:4, low means drive low |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output value |
| alertN | output | 1 | Active-low alert |
| fanOn | output | 1 | Fan mode enabled |
| fanSpeed | output | 3 | Fan speed register value |

## Verification
Change detection is driven with single rising edges, single falling edges and several bits changing together. These patterns tell apart a two-edge detector from a one-edge detector, and show whether a flag is held per pin or shared. Alerts are exercised with changes on masked-in and masked-out pins, with the enable off and then turned back on, and with both release paths. This shows whether the mask, the enable and the clear sources are each honoured separately. A pin change placed on the very clock of a status read shows whether the new flag is kept or dropped. Output tests mix push-pull and open-drain pins at both data levels in one pattern and then repeat it in fan mode, so that a drive-style or override mix-up shows on the pin outputs.

// File: rtl/gpio_alert_pkg.sv
package gpio_alert_pkg;

  localparam int REG_IDX_W   = 3;
  localparam int CFG_IE_BIT  = 0;
  localparam int CFG_FAN_BIT = 1;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_CFG    = 3'd0,
    IDX_DIR    = 3'd1,
    IDX_OTYPE  = 3'd2,
    IDX_STATUS = 3'd3,
    IDX_MASK   = 3'd4,
    IDX_DATA   = 3'd5,
    IDX_FAN    = 3'd6,
    IDX_NONE   = 3'd7
  } regIdxE;

  // Strobes from control to datapath, one per action.
  typedef struct packed {
    logic wrCfg;
    logic wrDir;
    logic wrOtype;
    logic wrMask;
    logic wrData;
    logic wrFan;
    logic rdStatus;
    logic ackAlert;
  } strobesT;

endpackage

// File: rtl/gpio_alert_ctrl.sv
module gpio_alert_ctrl
  import gpio_alert_pkg::*;
(
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic                 alertAck,
  output strobesT              strb,
  output regIdxE               rdSel
);

  regIdxE idx;

  always_comb begin
    idx  = regIdxE'(regIdx);
    strb = '0;
    // Status is read-only: index 3 has no write strobe.
    if (wrEn) begin
      case (idx)
        IDX_CFG:   strb.wrCfg   = 1'b1;
        IDX_DIR:   strb.wrDir   = 1'b1;
        IDX_OTYPE: strb.wrOtype = 1'b1;
        IDX_MASK:  strb.wrMask  = 1'b1;
        IDX_DATA:  strb.wrData  = 1'b1;
        IDX_FAN:   strb.wrFan   = 1'b1;
        default:   ;
      endcase
    end
    strb.rdStatus = rdEn && (idx == IDX_STATUS);
    strb.ackAlert = alertAck;
    rdSel         = idx;
  end

endmodule

// File: rtl/gpio_alert_datapath.sv
module gpio_alert_datapath
  import gpio_alert_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int FAN_PINS  = 4,
  parameter int FAN_SPD_W = 3,
  parameter logic [NPINS-1:0] DATA_RST = '1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobesT              strb,
  input  regIdxE               rdSel,
  input  logic [NPINS-1:0]     wrData,
  input  logic [NPINS-1:0]     pinIn,
  input  logic [FAN_PINS-1:0]  fanDrive,
  output logic [NPINS-1:0]     rdData,
  output logic [NPINS-1:0]     pinOe,
  output logic [NPINS-1:0]     pinOut,
  output logic                 alertN,
  output logic                 fanOn,
  output logic [FAN_SPD_W-1:0] fanSpeed
);

  localparam int FAN_LO = NPINS - FAN_PINS;

  logic                 ieQ, fanModeQ, alertQ;
  logic [NPINS-1:0]     dirQ, otypeQ, maskQ, dataQ, statusQ, prevPin;
  logic [FAN_SPD_W-1:0] fanSpdQ;
  logic [NPINS-1:0]     fanOwned, outEff, inEff, change;
  logic                 intHit;

  // Which pins the fan sequencer owns.
  for (genvar i = 0; i < NPINS; i++) begin : g_own
    if (i >= FAN_LO) begin : g_fan
      assign fanOwned[i] = fanModeQ;
    end else begin : g_gp
      assign fanOwned[i] = 1'b0;
    end
  end

  assign outEff = dirQ & ~fanOwned;
  assign inEff  = ~dirQ & ~fanOwned;
  assign change = (pinIn ^ prevPin) & inEff;
  assign intHit = ieQ && ((change & maskQ) != '0);

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ      <= 1'b0;
      fanModeQ <= 1'b0;
      dirQ     <= '0;
      otypeQ   <= '0;
      maskQ    <= '0;
      dataQ    <= DATA_RST;
      fanSpdQ  <= '0;
    end else begin
      if (strb.wrCfg) begin
        ieQ      <= wrData[CFG_IE_BIT];
        fanModeQ <= wrData[CFG_FAN_BIT];
      end
      if (strb.wrDir)   dirQ    <= wrData;
      if (strb.wrOtype) otypeQ  <= wrData;
      if (strb.wrMask)  maskQ   <= wrData;
      if (strb.wrData)  dataQ   <= wrData;
      if (strb.wrFan)   fanSpdQ <= wrData[FAN_SPD_W-1:0];
    end
  end

  // Previous pin sample, free running, so needs no reset
  always_ff @(posedge clk) begin
    prevPin <= pinIn;
  end

  // Status flags: the clear is applied before new events are merged in.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (strb.rdStatus ? '0 : statusQ) | change;
  end

  // Alert latch: a new event wins over a release on the same clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              alertQ <= 1'b0;
    else if (intHit)                        alertQ <= 1'b1;
    else if (strb.rdStatus || strb.ackAlert) alertQ <= 1'b0;
  end

  // Per-pin drivers
  for (genvar i = 0; i < NPINS; i++) begin : g_drv
    if (i >= FAN_LO) begin : g_fan
      always_comb begin
        if (fanModeQ) begin
          pinOe[i]  = ~fanDrive[i-FAN_LO];
          pinOut[i] = 1'b0;
        end else if (dirQ[i]) begin
          pinOe[i]  = otypeQ[i] | ~dataQ[i];
          pinOut[i] = otypeQ[i] & dataQ[i];
        end else begin
          pinOe[i]  = 1'b0;
          pinOut[i] = 1'b0;
        end
      end
    end else begin : g_gp
      always_comb begin
        if (dirQ[i]) begin
          pinOe[i]  = otypeQ[i] | ~dataQ[i];
          pinOut[i] = otypeQ[i] & dataQ[i];
        end else begin
          pinOe[i]  = 1'b0;
          pinOut[i] = 1'b0;
        end
      end
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    case (rdSel)
      IDX_CFG: begin
        rdData[CFG_IE_BIT]  = ieQ;
        rdData[CFG_FAN_BIT] = fanModeQ;
      end
      IDX_DIR:    rdData = dirQ;
      IDX_OTYPE:  rdData = otypeQ;
      IDX_STATUS: rdData = statusQ;
      IDX_MASK:   rdData = maskQ;
      IDX_DATA:   rdData = (dataQ & outEff) | (pinIn & ~outEff);
      IDX_FAN:    rdData[FAN_SPD_W-1:0] = fanSpdQ;
      default:    rdData = '0;
    endcase
  end

  assign alertN   = ~alertQ;
  assign fanOn    = fanModeQ;
  assign fanSpeed = fanSpdQ;

endmodule

// File: rtl/gpio_alert_port.sv
module gpio_alert_port
  import gpio_alert_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int FAN_PINS  = 4,
  parameter int FAN_SPD_W = 3
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [NPINS-1:0]     wrData,
  output logic [NPINS-1:0]     rdData,
  input  logic [NPINS-1:0]     pinIn,
  input  logic                 alertAck,
  input  logic [FAN_PINS-1:0]  fanDrive,
  output logic [NPINS-1:0]     pinOe,
  output logic [NPINS-1:0]     pinOut,
  output logic                 alertN,
  output logic                 fanOn,
  output logic [FAN_SPD_W-1:0] fanSpeed
);

  strobesT strb;
  regIdxE  rdSel;

  gpio_alert_ctrl u_ctrl (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .regIdx   (regIdx),
    .alertAck (alertAck),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  gpio_alert_datapath #(
    .NPINS     (NPINS),
    .FAN_PINS  (FAN_PINS),
    .FAN_SPD_W (FAN_SPD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .fanDrive (fanDrive),
    .rdData   (rdData),
    .pinOe    (pinOe),
    .pinOut   (pinOut),
    .alertN   (alertN),
    .fanOn    (fanOn),
    .fanSpeed (fanSpeed)
  );

endmodule

// File: rtl/gpio_alert_checks.sv
module gpio_alert_checks
  import gpio_alert_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int FAN_PINS = 4
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic [REG_IDX_W-1:0] regIdx,
  input logic [NPINS-1:0]     rdData,
  input logic [NPINS-1:0]     pinIn,
  input logic                 alertAck,
  input logic [NPINS-1:0]     pinOe,
  input logic [NPINS-1:0]     pinOut,
  input logic                 alertN,
  input logic                 fanOn
);

  localparam int FAN_LO = NPINS - FAN_PINS;

  logic stRead;
  assign stRead = rdEn && (regIdx == IDX_STATUS);

  // In fan mode the upper pins are never driven high.
  assert_fan_no_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    fanOn |-> ((pinOe[NPINS-1:FAN_LO] & pinOut[NPINS-1:FAN_LO]) == '0));

  // An acknowledge with no new pin change releases the alert.
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (alertAck && $stable(pinIn)) |=> alertN);

  // A status read with no new pin change releases the alert.
  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stRead && $stable(pinIn)) |=> alertN);

  // Back-to-back status reads with quiet pins: the second returns zero.
  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stRead && $stable(pinIn)) ##1 stRead |-> (rdData == '0));

  // The alert only falls after a pin change one clock earlier.
  assert_alert_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alertN) |-> ($past(pinIn) != $past(pinIn, 2)));

endmodule

bind gpio_alert_port gpio_alert_checks #(
  .NPINS    (NPINS),
  .FAN_PINS (FAN_PINS)
) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .rdEn     (rdEn),
  .regIdx   (regIdx),
  .rdData   (rdData),
  .pinIn    (pinIn),
  .alertAck (alertAck),
  .pinOe    (pinOe),
  .pinOut   (pinOut),
  .alertN   (alertN),
  .fanOn    (fanOn)
);

// File: tb/gpio_alert_port_bench.sv
module gpio_alert_port_bench;

  localparam logic [2:0] I_CFG = 3'd0, I_DIR = 3'd1, I_OTY = 3'd2, I_ST = 3'd3,
                         I_MSK = 3'd4, I_DAT = 3'd5, I_FAN = 3'd6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, alertAck = 1'b0;
  logic [2:0] regIdx = 3'd0;
  logic [7:0] wrData = 8'h00, pinIn = 8'h00;
  logic [3:0] fanDrive = 4'hF;
  logic [7:0] rdData, pinOe, pinOut;
  logic       alertN, fanOn;
  logic [2:0] fanSpeed;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_alert_port u_gpio_alert_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regIdx(regIdx),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .alertAck(alertAck),
    .fanDrive(fanDrive), .pinOe(pinOe), .pinOut(pinOut), .alertN(alertN),
    .fanOn(fanOn), .fanSpeed(fanSpeed)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic writeReg(logic [2:0] idx, logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; regIdx = idx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic readReg(logic [2:0] idx, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; regIdx = idx;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    #1;
  endtask

  task automatic setPins(logic [7:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic clearStatus();
    logic [7:0] v;
    readReg(I_ST, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pinOe", 32'(pinOe), 32'h00);
    check("R1 alertN", 32'(alertN), 32'h1);
    check("R1 fanOn", 32'(fanOn), 32'h0);
    readReg(I_CFG, v); check("R1 cfg", 32'(v), 32'h00);
    readReg(I_DIR, v); check("R1 dir", 32'(v), 32'h00);
    readReg(I_OTY, v); check("R1 otype", 32'(v), 32'h00);
    readReg(I_ST,  v); check("R1 status", 32'(v), 32'h00);
    readReg(I_MSK, v); check("R1 mask", 32'(v), 32'h00);
    readReg(I_DAT, v); check("R1 data reads pins", 32'(v), 32'h3C);
    readReg(I_FAN, v); check("R1 fan", 32'(v), 32'h00);
    writeReg(I_DIR, 8'hFF);
    check("R1 data resets high, open-drain released", 32'(pinOe), 32'h00);
    writeReg(I_DIR, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    writeReg(I_CFG, 8'hFF); readReg(I_CFG, v); check("R2 cfg bits", 32'(v), 32'h03);
    writeReg(I_DIR, 8'hA5); readReg(I_DIR, v); check("R2 dir", 32'(v), 32'hA5);
    writeReg(I_OTY, 8'h5A); readReg(I_OTY, v); check("R2 otype", 32'(v), 32'h5A);
    writeReg(I_MSK, 8'hC3); readReg(I_MSK, v); check("R2 mask", 32'(v), 32'hC3);
    writeReg(I_FAN, 8'hFF); readReg(I_FAN, v); check("R2 fan", 32'(v), 32'h07);
    check("R2 fanSpeed port", 32'(fanSpeed), 32'h7);
    writeReg(I_ST, 8'hFF);  readReg(I_ST, v);  check("R2 status write ignored", 32'(v), 32'h00);
    writeReg(I_CFG, 8'h00); writeReg(I_DIR, 8'h00); writeReg(I_OTY, 8'h00);
    writeReg(I_MSK, 8'h00); writeReg(I_FAN, 8'h00);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    setPins(8'hC0);
    writeReg(I_DAT, 8'h36);
    writeReg(I_OTY, 8'h03);
    writeReg(I_DIR, 8'h0F);
    check("R3 mixed oe", 32'(pinOe), 32'h0B);
    check("R3 mixed out", 32'(pinOut), 32'h02);
    readReg(I_DAT, v); check("R4 data readback", 32'(v), 32'hC6);
    writeReg(I_DAT, 8'hF0);
    check("R3 low data oe", 32'(pinOe), 32'h0F);
    check("R4 input bits not driven", 32'(pinOut), 32'h00);
    readReg(I_DAT, v); check("R4 input write ignored", 32'(v), 32'hC0);
    writeReg(I_DIR, 8'h00);
    check("R4 inputs released", 32'(pinOe), 32'h00);
    writeReg(I_OTY, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    setPins(8'h00); clearStatus();
    setPins(8'h81); tick();
    check("R7 no alert with enable off", 32'(alertN), 32'h1);
    readReg(I_ST, v); check("R5 rising edges", 32'(v), 32'h81);
    readReg(I_ST, v); check("R6 cleared by read", 32'(v), 32'h00);
    setPins(8'h01); tick();
    readReg(I_ST, v); check("R5 falling edge", 32'(v), 32'h80);
    writeReg(I_DIR, 8'h0F);
    setPins(8'h0E); tick();
    readReg(I_ST, v); check("R5 outputs set no flags", 32'(v), 32'h00);
    writeReg(I_DIR, 8'h00);
    clearStatus();
  endtask

  task automatic t_collision();
    logic [7:0] v;
    clearStatus();
    @(negedge clk);
    pinIn = pinIn ^ 8'h02; rdEn = 1'b1; regIdx = I_ST;
    #1 check("R6 read before event", 32'(rdData), 32'h00);
    @(negedge clk);
    rdEn = 1'b0;
    readReg(I_ST, v); check("R6 event kept across clear", 32'(v), 32'h02);
  endtask

  task automatic t_alert();
    logic [7:0] v;
    setPins(8'h00); clearStatus();
    writeReg(I_MSK, 8'h0C);
    writeReg(I_CFG, 8'h01);
    setPins(8'h01); tick();
    check("R7 unmasked pin no alert", 32'(alertN), 32'h1);
    setPins(8'h05); tick();
    check("R7 masked-in pin alerts", 32'(alertN), 32'h0);
    @(negedge clk); alertAck = 1'b1;
    @(negedge clk); alertAck = 1'b0; #1;
    check("R8 ack releases", 32'(alertN), 32'h1);
    readReg(I_ST, v); check("R8 status kept after ack", 32'(v), 32'h05);
    setPins(8'h0D); tick();
    check("R7 second alert", 32'(alertN), 32'h0);
    readReg(I_ST, v); check("R8 status read value", 32'(v), 32'h08);
    check("R8 read releases", 32'(alertN), 32'h1);
    writeReg(I_CFG, 8'h00);
    setPins(8'h09); tick();
    check("R7 enable off no alert", 32'(alertN), 32'h1);
    writeReg(I_CFG, 8'h01); tick();
    check("R7 no replay on enable", 32'(alertN), 32'h1);
    readReg(I_ST, v); check("R5 flag with enable off", 32'(v), 32'h04);
    writeReg(I_CFG, 8'h00); writeReg(I_MSK, 8'h00);
  endtask

  task automatic t_fan();
    logic [7:0] v;
    writeReg(I_DAT, 8'hFF); writeReg(I_OTY, 8'hFF); writeReg(I_DIR, 8'hFF);
    writeReg(I_FAN, 8'h05);
    @(negedge clk); fanDrive = 4'b1010;
    writeReg(I_CFG, 8'h02);
    check("R9 fanOn", 32'(fanOn), 32'h1);
    check("R9 fanSpeed", 32'(fanSpeed), 32'h5);
    check("R9 fan oe", 32'(pinOe), 32'h5F);
    check("R9 fan out", 32'(pinOut), 32'h0F);
    writeReg(I_DAT, 8'h00);
    check("R9 data ignored on fan pins oe", 32'(pinOe), 32'h5F);
    check("R9 data ignored on fan pins out", 32'(pinOut), 32'h00);
    writeReg(I_DIR, 8'h00); writeReg(I_MSK, 8'hFF);
    check("R9 direction ignored", 32'(pinOe), 32'h50);
    writeReg(I_CFG, 8'h03);
    clearStatus();
    setPins(pinIn ^ 8'hF0); tick();
    check("R9 fan pins no alert", 32'(alertN), 32'h1);
    readReg(I_ST, v); check("R9 fan pins no status", 32'(v), 32'h00);
    setPins(pinIn ^ 8'h02); tick();
    check("R9 low pins still alert", 32'(alertN), 32'h0);
    readReg(I_ST, v); check("R9 low pin status", 32'(v), 32'h02);
    writeReg(I_CFG, 8'h00); writeReg(I_MSK, 8'h00); writeReg(I_OTY, 8'h00);
    writeReg(I_FAN, 8'h00);
    check("R9 fan off", 32'(fanOn), 32'h0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pinIn = 8'h3C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_regs();
    t_drive();
    t_status();
    t_collision();
    t_alert();
    t_fan();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule